// File: doc/BRIEF.md
# Flow-Control Pause Frame Generator

This block produces a complete MAC-control pause frame, minus preamble and frame check sequence, whenever the flow-control logic asks for one. It takes a one-cycle request pulse together with a 16-bit pause time in quanta. The frame goes out one byte per handshake on a valid/ready stream, with an end-of-frame marker, to the transmit encapsulator. The encapsulator adds preamble, start delimiter and CRC.

A request is accepted only when three conditions hold together: the link runs full duplex, the link partner advertised pause capability, and local flow control is enabled. If any of them is false, the request is dropped and a one-cycle rejection pulse is raised. An accepted request that arrives while a frame is going out is held in a single pending slot. A later request overwrites the pending pause time, so the follow-up frame always carries the newest value.

The sequencer has two states. In IDLE it waits; the transition IDLE to SEND fires when a request is pending, which captures the pause time and the station address and clears the slot. SEND to SEND advances the byte index on each handshake. SEND to IDLE fires on the handshake of the last byte. From IDLE the next pending request starts a new frame one cycle later.

Top module: `pause_frame_gen`

## Requirements
- R1: After reset, tx_valid, tx_last and req_rejected are low and stay low until a request is accepted or rejected.
- R2: Frame bytes 0 to 5 are 0x01, 0x80, 0xC2, 0x00, 0x00, 0x01 (the reserved multicast destination).
- R3: Frame bytes 6 to 11 carry station_mac most significant byte first, as sampled on the cycle the frame begins.
- R4: Frame bytes 12 and 13 are 0x88, 0x08 (MAC-control type), and bytes 14 and 15 are 0x00, 0x01 (pause opcode).
- R5: Frame bytes 16 and 17 carry the pause time of the request, high byte first; every value from 0x0000 to 0xFFFF is carried unchanged.
- R6: Bytes 18 to 59 are zero, and every frame is exactly 60 bytes long.
- R7: tx_last is high only together with tx_valid on byte 59.
- R8: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last hold their values.
- R9: A request sampled while link_full_duplex, partner_pause_cap or flow_ctrl_en is low produces req_rejected high for exactly the next cycle and no frame.
- R10: An accepted request sampled with no frame in progress and nothing pending makes tx_valid rise in the second cycle after the request cycle.
- R11: Accepted requests sampled while a frame is being sent cause exactly one further frame carrying the newest pause time. It starts one cycle after the last byte of the current frame is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pause_req | input | 1 | One-cycle request to send a pause frame |
| pause_quanta | input | 16 | Pause time carried by the request |
| station_mac | input | 48 | Station source address |
| link_full_duplex | input | 1 | Link currently runs full duplex |
| partner_pause_cap | input | 1 | Link partner advertised pause capability |
| flow_ctrl_en | input | 1 | Local flow control enabled |
| tx_ready | input | 1 | Downstream accepts a byte |
| tx_valid | output | 1 | A frame byte is offered |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Marks the final byte of the frame |
| req_rejected | output | 1 | One-cycle pulse for a dropped request |

## Verification
The bench stalls the stream at random points to test byte holding and the last-byte marker. A design that advanced its index without a handshake would lose or repeat header bytes. A design that ignored the stall would change tx_data mid-wait. Several requests are stacked inside a running frame. A design that queued them all would send extra frames, and one that kept the oldest time would carry the wrong quanta. Requests are also fired with each enabling condition low in turn, and the extreme pause values 0x0000 and 0xFFFF are sent. These catch a gate that checks only one condition, a missing or stretched rejection pulse, and byte-swapped or truncated time fields.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    typedef enum logic [0:0] {
        PFG_IDLE = 1'b0,
        PFG_SEND = 1'b1
    } pfg_state_e;

    localparam logic [47:0] PFG_CTRL_DEST  = 48'h01_80_C2_00_00_01;
    localparam logic [15:0] PFG_CTRL_TYPE  = 16'h8808;
    localparam logic [15:0] PFG_PAUSE_OP   = 16'h0001;
    localparam int          PFG_HDR_BYTES  = 18;

endpackage

// File: rtl/pfg_req_arbiter.sv
module pfg_req_arbiter #(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [TIME_W-1:0] req_time,
    input  logic              full_duplex,
    input  logic              partner_cap,
    input  logic              fc_enable,
    input  logic              take,
    output logic              pend,
    output logic [TIME_W-1:0] pend_time,
    output logic              rejected
);

    logic allow;
    logic accept;

    assign allow  = full_duplex & partner_cap & fc_enable;
    assign accept = req & allow;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_time <= '0;
            rejected  <= 1'b0;
        end else begin
            pend     <= (pend & ~take) | accept;
            rejected <= req & ~allow;
            if (accept) begin
                pend_time <= req_time;
            end
        end
    end

    // R9
    reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rejected |-> ($past(req) && !($past(full_duplex) && $past(partner_cap) && $past(fc_enable))));

    // R11
    accept_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && full_duplex && partner_cap && fc_enable) |=> (pend && pend_time == $past(req_time)));

endmodule

// File: rtl/pfg_byte_sel.sv
module pfg_byte_sel
    import pfg_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int TIME_W = 16
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [47:0]       src_addr,
    input  logic [TIME_W-1:0] quanta,
    output logic [7:0]        byte_out
);

    localparam int HDR_BITS = PFG_HDR_BYTES * 8;

    logic [HDR_BITS-1:0] hdr;
    logic [7:0]          lane [PFG_HDR_BYTES];

    assign hdr = {PFG_CTRL_DEST, src_addr, PFG_CTRL_TYPE, PFG_PAUSE_OP, quanta};

    for (genvar g = 0; g < PFG_HDR_BYTES; g++) begin : g_lane
        assign lane[g] = (idx == IDX_W'(g)) ? hdr[HDR_BITS-1-8*g -: 8] : 8'h00;
    end

    always_comb begin
        byte_out = 8'h00;
        for (int k = 0; k < PFG_HDR_BYTES; k++) begin
            byte_out = byte_out | lane[k];
        end
    end

endmodule

// File: rtl/pfg_tx_seq.sv
module pfg_tx_seq
    import pfg_pkg::*;
#(
    parameter int FRAME_BYTES = 60,
    parameter int TIME_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend,
    input  logic [TIME_W-1:0] pend_time,
    input  logic [47:0]       station_addr,
    input  logic              tx_ready,
    output logic              take,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last
);

    localparam int               IDX_W    = $clog2(FRAME_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

    pfg_state_e        state, state_nx;
    logic [IDX_W-1:0]  idx;
    logic [47:0]       cap_addr;
    logic [TIME_W-1:0] cap_time;
    logic              hs;

    assign hs   = (state == PFG_SEND) && tx_ready;
    assign take = (state == PFG_IDLE) && pend;

    always_comb begin
        state_nx = state;
        unique case (state)
            PFG_IDLE: if (pend) state_nx = PFG_SEND;
            PFG_SEND: if (tx_ready && idx == LAST_IDX) state_nx = PFG_IDLE;
            default:  state_nx = PFG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PFG_IDLE;
            idx      <= '0;
            cap_addr <= '0;
            cap_time <= '0;
        end else begin
            state <= state_nx;
            if (take) begin
                idx      <= '0;
                cap_addr <= station_addr;
                cap_time <= pend_time;
            end else if (hs && idx != LAST_IDX) begin
                idx <= idx + 1'b1;
            end
        end
    end

    pfg_byte_sel #(
        .IDX_W  (IDX_W),
        .TIME_W (TIME_W)
    ) u_sel (
        .idx      (idx),
        .src_addr (cap_addr),
        .quanta   (cap_time),
        .byte_out (tx_data)
    );

    always_comb begin
        tx_valid = 1'b0;
        tx_last  = 1'b0;
        unique case (state)
            PFG_IDLE: ;
            PFG_SEND: begin
                tx_valid = 1'b1;
                tx_last  = (idx == LAST_IDX);
            end
            default: ;
        endcase
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R7
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    // R6
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LAST_IDX);

    // R10
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_valid && pend) |=> (tx_valid && !tx_last));

    // R11
    end_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_last && tx_ready) |=> !tx_valid);

endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen #(
    parameter int FRAME_BYTES = 60,
    parameter int TIME_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pause_req,
    input  logic [TIME_W-1:0] pause_quanta,
    input  logic [47:0]       station_mac,
    input  logic              link_full_duplex,
    input  logic              partner_pause_cap,
    input  logic              flow_ctrl_en,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              req_rejected
);

    logic              pend;
    logic [TIME_W-1:0] pend_time;
    logic              take;

    pfg_req_arbiter #(
        .TIME_W (TIME_W)
    ) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (pause_req),
        .req_time    (pause_quanta),
        .full_duplex (link_full_duplex),
        .partner_cap (partner_pause_cap),
        .fc_enable   (flow_ctrl_en),
        .take        (take),
        .pend        (pend),
        .pend_time   (pend_time),
        .rejected    (req_rejected)
    );

    pfg_tx_seq #(
        .FRAME_BYTES (FRAME_BYTES),
        .TIME_W      (TIME_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .pend         (pend),
        .pend_time    (pend_time),
        .station_addr (station_mac),
        .tx_ready     (tx_ready),
        .take         (take),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .tx_last      (tx_last)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!tx_valid && !req_rejected));

endmodule

// File: tb/pause_frame_gen_test.sv
module pause_frame_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int NBYTES     = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pause_req = 1'b0;
    logic [15:0] pause_quanta = '0;
    logic [47:0] station_mac = 48'h02_11_22_33_44_55;
    logic        link_full_duplex = 1'b0;
    logic        partner_pause_cap = 1'b0;
    logic        flow_ctrl_en = 1'b0;
    logic        tx_ready = 1'b1;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        req_rejected;

    int vectors = 0;
    int miscompares = 0;
    int random_ready = 0;
    logic [15:0] lfsr = 16'hACE1;

    pause_frame_gen uut (
        .clk               (clk),
        .rst_n             (rst_n),
        .pause_req         (pause_req),
        .pause_quanta      (pause_quanta),
        .station_mac       (station_mac),
        .link_full_duplex  (link_full_duplex),
        .partner_pause_cap (partner_pause_cap),
        .flow_ctrl_en      (flow_ctrl_en),
        .tx_ready          (tx_ready),
        .tx_valid          (tx_valid),
        .tx_data           (tx_data),
        .tx_last           (tx_last),
        .req_rejected      (req_rejected)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [7:0] spec_byte(int i, logic [47:0] a, logic [15:0] t);
        logic [7:0] dst [6];
        dst = '{8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h01};
        if (i < 6)   return dst[i];
        if (i < 12)  return a[8*(11-i) +: 8];
        if (i == 12) return 8'h88;
        if (i == 13) return 8'h08;
        if (i == 14) return 8'h00;
        if (i == 15) return 8'h01;
        if (i == 16) return t[15:8];
        if (i == 17) return t[7:0];
        return 8'h00;
    endfunction

    function automatic string tag_of(int i);
        if (i < 6)  return "R2";
        if (i < 12) return "R3";
        if (i < 16) return "R4";
        if (i < 18) return "R5";
        return "R6";
    endfunction

    // ready driver: changes a quarter period after the rising edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_ready = (random_ready != 0) ? lfsr[0] | lfsr[3] : 1'b1;
    end

    // behavioural reference model
    logic [7:0]  m_q [$];
    logic        m_send = 1'b0;
    logic        m_pend = 1'b0;
    logic [15:0] m_time = '0;
    logic        m_rej = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete();
            m_send = 1'b0;
            m_pend = 1'b0;
            m_rej  = 1'b0;
        end else begin
            m_rej = pause_req && !(link_full_duplex && partner_pause_cap && flow_ctrl_en);
            if (m_send) begin
                if (tx_ready) begin
                    void'(m_q.pop_front());
                    if (m_q.size() == 0) m_send = 1'b0;
                end
            end else if (m_pend) begin
                for (int i = 0; i < NBYTES; i++) m_q.push_back(spec_byte(i, station_mac, m_time));
                m_pend = 1'b0;
                m_send = 1'b1;
            end
            if (pause_req && link_full_duplex && partner_pause_cap && flow_ctrl_en) begin
                m_pend = 1'b1;
                m_time = pause_quanta;
            end
        end
    end

    // per-clock comparison and frame capture, away from the rising edge
    logic [7:0] got_frame [NBYTES];
    int cap_idx = 0;
    int frames_done = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            check("R10 R11 valid", 64'(tx_valid), 64'(m_send));
            check("R9 rejected", 64'(req_rejected), 64'(m_rej));
            if (m_send && tx_valid) begin
                check({tag_of(NBYTES - m_q.size()), " data"}, 64'(tx_data), 64'(m_q[0]));
                check("R7 last", 64'(tx_last), 64'(m_q.size() == 1));
            end
            if (tx_valid && tx_ready) begin
                if (cap_idx < NBYTES) got_frame[cap_idx] = tx_data;
                cap_idx++;
                if (tx_last) begin
                    check("R6 length", 64'(cap_idx), 64'(NBYTES));
                    cap_idx = 0;
                    frames_done++;
                end
            end
        end
    end

    task automatic pulse_req(input logic [15:0] t);
        @(negedge clk);
        pause_req = 1'b1;
        pause_quanta = t;
        @(negedge clk);
        pause_req = 1'b0;
    endtask

    task automatic wait_frames(input int n);
        int guard = 0;
        while (frames_done < n && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        if (frames_done < n) begin
            miscompares++;
            $display("FAIL watchdog: got %0d frames expected %0d", frames_done, n);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic check_frame(input logic [47:0] a, input logic [15:0] t);
        for (int i = 0; i < NBYTES; i++) begin
            check({tag_of(i), " frame byte"}, 64'(got_frame[i]), 64'(spec_byte(i, a, t)));
        end
    endtask

    initial begin
        int base;
        repeat (4) @(negedge clk);
        // R1
        check("R1 valid", 64'(tx_valid), 64'd0);
        check("R1 last", 64'(tx_last), 64'd0);
        check("R1 rejected", 64'(req_rejected), 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle valid", 64'(tx_valid), 64'd0);

        link_full_duplex = 1'b1;
        partner_pause_cap = 1'b1;
        flow_ctrl_en = 1'b1;

        // R10 single frame, R2..R6 contents
        pulse_req(16'h1234);
        check("R10 not yet", 64'(tx_valid), 64'd0);
        @(negedge clk);
        check("R10 rises", 64'(tx_valid), 64'd1);
        wait_frames(1);
        check_frame(48'h02_11_22_33_44_55, 16'h1234);

        // R8 under backpressure, R5 max value
        random_ready = 1;
        station_mac = 48'hA0_B1_C2_D3_E4_F5;
        pulse_req(16'hFFFF);
        wait_frames(2);
        check_frame(48'hA0_B1_C2_D3_E4_F5, 16'hFFFF);

        // R9 each condition low in turn
        base = frames_done;
        link_full_duplex = 1'b0;
        pulse_req(16'h0011);
        check("R9 duplex pulse", 64'(req_rejected), 64'd1);
        @(negedge clk);
        check("R9 pulse ends", 64'(req_rejected), 64'd0);
        link_full_duplex = 1'b1;
        partner_pause_cap = 1'b0;
        pulse_req(16'h0022);
        check("R9 partner pulse", 64'(req_rejected), 64'd1);
        partner_pause_cap = 1'b1;
        flow_ctrl_en = 1'b0;
        pulse_req(16'h0033);
        check("R9 enable pulse", 64'(req_rejected), 64'd1);
        flow_ctrl_en = 1'b1;
        repeat (10) @(negedge clk);
        check("R9 no frame", 64'(frames_done), 64'(base));
        check("R9 idle", 64'(tx_valid), 64'd0);

        // R11 stacked requests during a frame
        random_ready = 0;
        pulse_req(16'h0100);
        repeat (10) @(negedge clk);
        pulse_req(16'h0200);
        repeat (5) @(negedge clk);
        pulse_req(16'h0300);
        wait_frames(base + 2);
        check_frame(48'hA0_B1_C2_D3_E4_F5, 16'h0300);
        repeat (80) @(negedge clk);
        check("R11 exactly one more", 64'(frames_done), 64'(base + 2));

        // R5 zero time, reject while busy
        random_ready = 1;
        pulse_req(16'h0000);
        repeat (4) @(negedge clk);
        link_full_duplex = 1'b0;
        pulse_req(16'h4444);
        check("R9 busy reject", 64'(req_rejected), 64'd1);
        link_full_duplex = 1'b1;
        wait_frames(base + 3);
        check_frame(48'hA0_B1_C2_D3_E4_F5, 16'h0000);
        repeat (80) @(negedge clk);
        check("R9 busy no extra", 64'(frames_done), 64'(base + 3));

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule